// File: doc/BRIEF.md
# UART Register Front-End

This block is the register side of a UART, sitting on an APB-style slave port. It turns APB accesses into byte traffic. Bytes arriving on a receive stream are stored in a linear buffer. Software drains that buffer by reading the data register. Bytes that software writes to the data register leave on a transmit stream that uses a valid/ready handshake. A single interrupt line gives one-clock pulses when a byte is received or sent, if the matching enable bit is set.

The receive buffer is written at one index and read at another. Both indices go back to zero only when every stored byte has been read. As a result, room in the buffer is recovered only by draining it completely. A data write that cannot be handed to the transmit stream straight away is held in a one-byte register, and PREADY stays low until the stream accepts it. Bit timing, baud generation, parity and the scaler function are not part of this block.

Top module: `uart_regfront`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0x0000_0006 (bit 1 and bit 2 set), and the receive buffer is empty.
- R2: The 8-bit offset decodes as follows. 0x00 and 0x03 are the data register, 0x04 is status and 0x08 is control. The scaler at 0x0C reads 0 and ignores writes. Every other offset reads 0.
- R3: All 32 bits of the control register read back exactly as written. Writes to the status register leave its value unchanged.
- R4: A byte offered on the receive stream while control bit 0 (receive enable) is clear is consumed and discarded. It does not change the status register or the data register.
- R5: With receive enable set, reads of the data register return the accepted bytes in arrival order. Status bit 0 (data ready) is 1 while unread bytes remain and 0 once the last one has been read.
- R6: A data read while the buffer is empty returns 0.
- R7: A data write while control bit 1 (transmit enable) is set puts the low byte of the write data on the transmit stream, exactly once. With the bit clear, the write completes without waiting and nothing is sent.
- R8: If the transmit stream is not ready, the pending byte stays on tx_data with tx_valid high, and PREADY stays low until the handshake completes.
- R9: The interrupt pulse appears in the cycle after a received byte is stored (when control bit 2 is set) or after a byte is sent (when control bit 3 is set). Events in the same cycle give a single one-cycle pulse. With the enable bit clear, the event gives no pulse.
- R10: The buffer holds DEPTH bytes. Status bit 8 is 1 when at least DEPTH/2 bytes are unread. Once DEPTH bytes have been written, rx_ready stays low and status bit 10 stays 1 until the buffer is fully read. After that the indices return to zero and reception resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 8 | Register byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB transfer complete |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Buffer has room |
| tx_data | output | 8 | Byte to send |
| tx_valid | output | 1 | Byte to send is pending |
| tx_ready | input | 1 | Sink accepts the byte |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with DEPTH set to 8. This lets the full-buffer stall, the half-full flag and the collapse of both indices back to zero be reached after a few transfers. A receive byte is held waiting at the full buffer while the buffer is drained, which shows that only a complete drain restores room. Stalling the transmit sink makes the held byte, the low PREADY and a receive event coinciding with the transmit handshake all observable at the ports.

// File: rtl/uart_regfront.sv
module uart_regfront #(
  parameter int DEPTH = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [7:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic        irq
);
  localparam int IW = $clog2(DEPTH) + 1;
  localparam logic [IW-1:0] FULL_AT = IW'(DEPTH);
  localparam logic [IW-1:0] HALF_AT = IW'(DEPTH / 2);

  logic [7:0]    fifo_mem [DEPTH];
  logic [IW-1:0] wr_idx, rd_idx, wr_nx, rd_nx, fill;
  logic [31:0]   ctrl_q, status;
  logic [7:0]    hold_q;
  logic          hold_v, irq_q;

  wire acc      = psel && penable;
  wire sel_data = (paddr == 8'h00) || (paddr == 8'h03);
  wire has_data = rd_idx != wr_idx;
  wire rx_push  = rx_valid && rx_ready && ctrl_q[0];
  wire rd_pop   = acc && !pwrite && sel_data && has_data;
  wire tx_fire  = hold_v && tx_ready;
  wire tx_load  = acc && pwrite && sel_data && !hold_v && ctrl_q[1];

  assign rx_ready = wr_idx != FULL_AT;
  assign fill     = wr_idx - rd_idx;
  assign status   = {21'b0, !rx_ready, 1'b0, fill >= HALF_AT, 5'b0, 2'b11, has_data};
  assign pready   = !(acc && pwrite && sel_data && (hold_v ? !tx_ready : ctrl_q[1]));
  assign tx_data  = hold_q;
  assign tx_valid = hold_v;
  assign irq      = irq_q;

  always_comb begin
    wr_nx = wr_idx + IW'(rx_push);
    rd_nx = rd_idx + IW'(rd_pop);
    if (rd_pop && rd_nx == wr_nx) begin
      wr_nx = '0;
      rd_nx = '0;
    end
  end

  always_comb begin
    case (paddr)
      8'h00, 8'h03: prdata = has_data ? {24'b0, fifo_mem[rd_idx[IW-2:0]]} : 32'b0;
      8'h04:        prdata = status;
      8'h08:        prdata = ctrl_q;
      default:      prdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rx_push) fifo_mem[wr_idx[IW-2:0]] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
      ctrl_q <= '0;
      hold_q <= '0;
      hold_v <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      wr_idx <= wr_nx;
      rd_idx <= rd_nx;
      if (acc && pwrite && paddr == 8'h08) ctrl_q <= pwdata;
      if (tx_load) begin
        hold_q <= pwdata[7:0];
        hold_v <= 1'b1;
      end else if (tx_fire) begin
        hold_v <= 1'b0;
      end
      irq_q <= (rx_push && ctrl_q[2]) || (tx_fire && ctrl_q[3]);
    end
  end
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk #(
  parameter int DEPTH = 1024,
  localparam int IW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [7:0]    paddr,
  input logic [31:0]   prdata,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          irq,
  input logic [IW-1:0] wr_idx,
  input logic [IW-1:0] rd_idx,
  input logic [31:0]   ctrl_q
);
  AST_IDX_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx <= wr_idx) && (wr_idx <= IW'(DEPTH))); // R10
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && !pwrite && (paddr == 8'h00 || paddr == 8'h03) && rd_idx == wr_idx)
      |-> prdata == 32'b0); // R6
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past((rx_valid && rx_ready && ctrl_q[0] && ctrl_q[2]) ||
                  (tx_valid && tx_ready && ctrl_q[3]))); // R9
  AST_RX_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !ctrl_q[0] && !(psel && penable && !pwrite))
      |=> $stable(wr_idx)); // R4
endmodule

bind uart_regfront uart_regfront_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .prdata(prdata), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .irq(irq),
  .wr_idx(wr_idx), .rd_idx(rd_idx), .ctrl_q(ctrl_q)
);

// File: tb/uart_regfront_tb_top.sv
module uart_regfront_tb_top;
  localparam int CLK_P = 10;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready;
  logic [7:0] rx_data = '0, tx_data;
  logic rx_valid = 0, rx_ready, tx_valid, tx_ready = 0, irq;

  int checks = 0, failures = 0, irq_hi = 0, tx_sent = 0;
  logic [7:0] exp_q [$];

  always #(CLK_P/2) clk = ~clk;

  uart_regfront #(.DEPTH(DEPTH)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(negedge clk) begin
    #2;
    if (irq) irq_hi++;
    if (tx_valid && tx_ready) begin
      tx_sent++;
      if (exp_q.size() == 0) chk(0, "R7 unexpected tx byte", {24'b0, tx_data}, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(tx_data == e, "R7 tx byte", {24'b0, tx_data}, {24'b0, e});
      end
    end
  end

  task automatic apb(input bit wr, input logic [7:0] a, input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    #1;
    while (!pready) begin @(negedge clk); #1; end
    r = prdata;
    @(posedge clk); #1;
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] r;
    apb(1, a, d, r);
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string req);
    logic [31:0] r;
    apb(0, a, 0, r);
    chk(r == e, req, r, e);
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    #1;
    while (!rx_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    rx_valid = 0;
  endtask

  initial begin
    #(CLK_P * 50000);
    chk(0, "watchdog expired", 0, 0);
    summary();
    $finish;
  end

  initial begin
    int h;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_chk(8'h08, 32'h0, "R1 control after reset");
    rd_chk(8'h04, 32'h6, "R1 status after reset");
    rd_chk(8'h00, 32'h0, "R6 empty data read after reset");

    wr(8'h08, 32'hFFFF_FFF0);
    rd_chk(8'h08, 32'hFFFF_FFF0, "R3 control readback all ones");
    wr(8'h08, 32'h8000_1AB0);
    rd_chk(8'h08, 32'h8000_1AB0, "R3 control readback pattern");
    wr(8'h04, 32'hFFFF_FFFF);
    rd_chk(8'h04, 32'h6, "R3 status write ignored");
    wr(8'h0C, 32'h1234);
    rd_chk(8'h0C, 32'h0, "R2 scaler reads zero");
    rd_chk(8'h10, 32'h0, "R2 unmapped offset reads zero");

    wr(8'h08, 32'h0);
    send_rx(8'h55);
    rd_chk(8'h04, 32'h6, "R4 disabled receive leaves status");
    rd_chk(8'h00, 32'h0, "R4 disabled receive stores nothing");

    wr(8'h08, 32'h1);
    send_rx(8'h11); send_rx(8'h22); send_rx(8'h33);
    rd_chk(8'h04, 32'h7, "R5 data ready set");
    rd_chk(8'h00, 32'h11, "R5 first byte");
    rd_chk(8'h03, 32'h22, "R2 data via offset 3");
    rd_chk(8'h00, 32'h33, "R5 third byte");
    rd_chk(8'h04, 32'h6, "R5 data ready cleared");
    rd_chk(8'h00, 32'h0, "R6 read after drain");

    for (int i = 0; i < DEPTH; i++) send_rx(8'(i + 8'hA0));
    rd_chk(8'h04, 32'h507, "R10 full and half flags");
    @(negedge clk); #1;
    chk(rx_ready == 0, "R10 rx_ready low when full", {31'b0, rx_ready}, 0);
    rx_valid = 1; rx_data = 8'hEE;
    rd_chk(8'h00, 32'hA0, "R10 first byte of full buffer");
    rd_chk(8'h04, 32'h507, "R10 still no room after one read");
    #1;
    chk(rx_ready == 0, "R10 rx_ready stays low until drained", {31'b0, rx_ready}, 0);
    for (int i = 1; i < DEPTH; i++) rd_chk(8'h00, 32'(8'hA0 + i), "R10 drain order");
    @(negedge clk); #1;
    chk(rx_ready == 1, "R10 rx_ready back after drain", {31'b0, rx_ready}, 1);
    @(posedge clk); #1;
    rx_valid = 0;
    rd_chk(8'h00, 32'hEE, "R10 waiting byte accepted after drain");
    rd_chk(8'h04, 32'h6, "R10 status empty again");

    wr(8'h08, 32'h2);
    tx_ready = 1;
    exp_q.push_back(8'hA5);
    wr(8'h00, 32'h1234_56A5);
    repeat (2) @(negedge clk);
    chk(tx_sent == 1, "R7 one byte sent", tx_sent, 1);
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h77);
    repeat (3) @(negedge clk);
    chk(tx_sent == 1, "R7 disabled transmit sends nothing", tx_sent, 1);

    wr(8'h08, 32'h2);
    tx_ready = 0;
    exp_q.push_back(8'h3C);
    fork
      wr(8'h03, 32'h3C);
      begin
        repeat (5) @(negedge clk);
        #2;
        chk(pready == 0, "R8 pready held low", {31'b0, pready}, 0);
        chk(tx_valid == 1 && tx_data == 8'h3C, "R8 byte held", {23'b0, tx_valid, tx_data}, 32'h13C);
        @(negedge clk);
        tx_ready = 1;
      end
    join
    repeat (2) @(negedge clk);
    chk(tx_sent == 2, "R8 held byte sent once", tx_sent, 2);

    wr(8'h08, 32'h5);
    h = irq_hi;
    send_rx(8'h61);
    repeat (2) @(negedge clk);
    chk(irq_hi == h + 1, "R9 receive pulse", irq_hi - h, 1);
    rd_chk(8'h00, 32'h61, "R5 single byte");
    wr(8'h08, 32'h1);
    h = irq_hi;
    send_rx(8'h62);
    repeat (2) @(negedge clk);
    chk(irq_hi == h, "R9 no pulse without enable", irq_hi - h, 0);
    rd_chk(8'h00, 32'h62, "R5 single byte again");
    wr(8'h08, 32'hA);
    h = irq_hi;
    exp_q.push_back(8'h70);
    wr(8'h00, 32'h70);
    repeat (2) @(negedge clk);
    chk(irq_hi == h + 1, "R9 transmit pulse", irq_hi - h, 1);

    wr(8'h08, 32'hF);
    tx_ready = 0;
    h = irq_hi;
    exp_q.push_back(8'h99);
    fork
      wr(8'h00, 32'h99);
      begin
        repeat (3) @(negedge clk);
        rx_valid = 1; rx_data = 8'h42; tx_ready = 1;
        @(negedge clk);
        rx_valid = 0;
      end
    join
    repeat (3) @(negedge clk);
    chk(irq_hi == h + 1, "R9 coincident events one pulse", irq_hi - h, 1);
    rd_chk(8'h00, 32'h42, "R9 coincident receive stored");
    chk(exp_q.size() == 0, "R7 all expected bytes sent", exp_q.size(), 0);

    summary();
    $finish;
  end
endmodule